// File: doc/BRIEF.md
# Boot ROM Overlay Controller

This block sits in the glue logic of a 68000-family board and decides, for every bus cycle, whether the flash ROM or the onboard RAM is selected. Its job is to keep a valid exception vector table at address zero from the moment the board comes out of a hard reset. It does this by holding a boot-mode flag. While the flag is set, any CPU read in the lowest 256 KB is steered to the flash ROM. Writes to that same range still reach the RAM underneath, so firmware can copy the vectors down while an interrupt taken in the meantime still finds good vectors.

The flag is not cleared by a cycle count. Firmware leaves boot mode when it makes a supervisor data access, either a read or a write, anywhere in the middle half of any 1 MB bank. The flag drops one system clock after the address strobe rises at the end of that cycle. From then on, the low region decodes to RAM in both directions. Only a true hard reset, with /RESET and /HALT asserted together, puts the board back into boot mode. The /RESET pulse that the CPU's own reset instruction drives has no effect on the flag.

All logic runs on the system clock. The strobe edge is found by comparing the strobe with its registered copy. Chip selects are combinational from the bus and the flag, and are asserted only while /AS is low.

Top module: `boot_ovl_ctrl`

## Requirements
- R1: After the asynchronous reset rst_ni, boot mode is active, and both chip selects are high while as_n_i is high.
- R2: In boot mode, a read (rw_i=1) with address bits [23:18] all zero drives rom_cs_n_o low and ram_cs_n_o high.
- R3: A write (rw_i=0) with address bits [23:18] all zero drives ram_cs_n_o low and rom_cs_n_o high in either mode.
- R4: A cycle with fc_i=3'b101 (supervisor data), read or write, whose address bits [19:18] are 2'b01 or 2'b10, ends boot mode. The value of address bits [23:20] and [17:0] does not matter.
- R5: A cycle with any other fc_i value leaves boot mode set, including 3'b110 (supervisor program) and 3'b001 (user data). So does a supervisor data cycle whose bits [19:18] are 2'b00 or 2'b11.
- R6: Boot mode ends on the first clock edge at which as_n_i is sampled high after the qualifying cycle. It never ends while the strobe is held low. A read of the low region in the next cycle selects RAM.
- R7: Outside boot mode, reads and writes with address bits [23:18] zero select RAM and not ROM.
- R8: Sampling reset_n_i and halt_n_i both low on a clock edge sets boot mode. reset_n_i low with halt_n_i high leaves the flag unchanged.
- R9: Addresses whose bits [23:20] equal ROM_BASE bits [23:20] (default 4'hE) select ROM, and addresses whose bits [23:20] are zero select RAM (apart from the overlay), the same way in both modes. The two selects are never low together.
- R10: When a hard reset is sampled on the same edge as the strobe rise that would end boot mode, boot mode stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| addr_i | input | ADDR_W | CPU address bus |
| fc_i | input | 3 | Function code lines, FC2 in bit 2 |
| rw_i | input | 1 | 1 = read, 0 = write |
| as_n_i | input | 1 | Address strobe, active low |
| reset_n_i | input | 1 | Bus /RESET, active low |
| halt_n_i | input | 1 | Bus /HALT, active low |
| rom_cs_n_o | output | 1 | Flash ROM select, active low |
| ram_cs_n_o | output | 1 | RAM select, active low |

## Verification
A hard reset and the strobe rise that ends a qualifying cycle can land on the same clock edge. One input tries to set the flag while the other tries to clear it. The bench provokes this by pulling /RESET and /HALT low at the very drive point where it raises /AS after a supervisor data access to the trigger window. It then judges the outcome by reading the low region and expecting the ROM select. The exhaustive sweeps cover every combination of the upper address bits, function code and direction, in both modes, against an arithmetic model of the flag.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;
  localparam logic [2:0] FC_SUP_DATA = 3'b101;

  // middle half of a 1 MB bank: bits [19:18] = 01 or 10
  function automatic logic in_trig_window(input logic [1:0] bank_q);
    return bank_q == 2'b01 || bank_q == 2'b10;
  endfunction
endpackage

// File: rtl/boot_ovl_decode.sv
module boot_ovl_decode
  import boot_ovl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned OVL_BITS  = 18,
  parameter int unsigned BANK_BITS = 20,
  parameter int unsigned RAM_BITS  = 20,
  parameter int unsigned ROM_BITS  = 20,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'hE00000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic              rw_i,
  input  logic              as_n_i,
  input  logic              boot_i,
  output logic              rom_sel_o,
  output logic              ram_sel_o,
  output logic              trig_hit_o
);
  logic low_hit, rom_hit, ram_hit, overlay;

  assign low_hit = addr_i[ADDR_W-1:OVL_BITS] == '0;
  assign rom_hit = addr_i[ADDR_W-1:ROM_BITS] == ROM_BASE[ADDR_W-1:ROM_BITS];
  assign ram_hit = addr_i[ADDR_W-1:RAM_BITS] == '0;
  assign overlay = boot_i & low_hit & rw_i;

  assign rom_sel_o  = ~as_n_i & (rom_hit | overlay);
  assign ram_sel_o  = ~as_n_i & ram_hit & ~overlay;
  assign trig_hit_o = (fc_i == FC_SUP_DATA) &&
                      in_trig_window(addr_i[BANK_BITS-1 -: 2]);
endmodule

// File: rtl/boot_ovl_strobe.sv
module boot_ovl_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_n_i,
  input  logic hit_i,
  output logic exit_o
);
  logic as_q, hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_q  <= 1'b1;
      hit_q <= 1'b0;
    end else begin
      as_q <= as_n_i;
      if (!as_n_i) hit_q <= hit_i;  // last sample inside the strobe wins
    end
  end

  assign exit_o = as_n_i & ~as_q & hit_q;
endmodule

// File: rtl/boot_ovl_flag.sv
module boot_ovl_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic boot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    boot_o <= 1'b1;
    else if (set_i) boot_o <= 1'b1;  // hard reset outranks exit
    else if (clr_i) boot_o <= 1'b0;
  end
endmodule

// File: rtl/boot_ovl_ctrl.sv
module boot_ovl_ctrl #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned OVL_BITS  = 18,
  parameter int unsigned BANK_BITS = 20,
  parameter int unsigned RAM_BITS  = 20,
  parameter int unsigned ROM_BITS  = 20,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'hE00000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic              rw_i,
  input  logic              as_n_i,
  input  logic              reset_n_i,
  input  logic              halt_n_i,
  output logic              rom_cs_n_o,
  output logic              ram_cs_n_o
);
  logic boot_q, rom_sel, ram_sel, trig_hit, exit_p, hard_rst;

  assign hard_rst = ~reset_n_i & ~halt_n_i;

  boot_ovl_decode #(
    .ADDR_W(ADDR_W), .OVL_BITS(OVL_BITS), .BANK_BITS(BANK_BITS),
    .RAM_BITS(RAM_BITS), .ROM_BITS(ROM_BITS), .ROM_BASE(ROM_BASE)
  ) u_dec (
    .addr_i(addr_i), .fc_i(fc_i), .rw_i(rw_i), .as_n_i(as_n_i),
    .boot_i(boot_q), .rom_sel_o(rom_sel), .ram_sel_o(ram_sel),
    .trig_hit_o(trig_hit)
  );

  boot_ovl_strobe u_stb (
    .clk_i(clk_i), .rst_ni(rst_ni), .as_n_i(as_n_i),
    .hit_i(trig_hit), .exit_o(exit_p)
  );

  boot_ovl_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(hard_rst),
    .clr_i(exit_p), .boot_o(boot_q)
  );

  assign rom_cs_n_o = ~rom_sel;
  assign ram_cs_n_o = ~ram_sel;
endmodule

// File: rtl/boot_ovl_chk.sv
module boot_ovl_chk #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned OVL_BITS = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rw_i,
  input logic              as_n_i,
  input logic              reset_n_i,
  input logic              halt_n_i,
  input logic              rom_cs_n_o,
  input logic              ram_cs_n_o,
  input logic              boot_i
);
  logic low;
  assign low = addr_i[ADDR_W-1:OVL_BITS] == '0;

  AST_BOOT_READ_ROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_i && !as_n_i && rw_i && low |-> !rom_cs_n_o && ram_cs_n_o); // R2
  AST_LOW_WRITE_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_n_i && !rw_i && low |-> !ram_cs_n_o && rom_cs_n_o); // R3
  AST_EXIT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(boot_i) |-> $past(as_n_i) && !$past(as_n_i, 2)); // R6
  AST_NORMAL_LOW_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_i && !as_n_i && low |-> !ram_cs_n_o && rom_cs_n_o); // R7
  AST_HARD_RST_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reset_n_i && !halt_n_i |=> boot_i); // R8
  AST_SET_ONLY_HARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(boot_i) |-> $past(!reset_n_i && !halt_n_i)); // R8
  AST_SEL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~rom_cs_n_o, ~ram_cs_n_o}) <= 1); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_n_i |-> rom_cs_n_o && ram_cs_n_o); // R1
endmodule

bind boot_ovl_ctrl boot_ovl_chk #(.ADDR_W(ADDR_W), .OVL_BITS(OVL_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rw_i(rw_i),
  .as_n_i(as_n_i), .reset_n_i(reset_n_i), .halt_n_i(halt_n_i),
  .rom_cs_n_o(rom_cs_n_o), .ram_cs_n_o(ram_cs_n_o), .boot_i(boot_q)
);

// File: tb/boot_ovl_ctrl_bench.sv
`timescale 1ns/1ps
module boot_ovl_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] addr_i = '0;
  logic [2:0]  fc_i = 3'b000;
  logic        rw_i = 1'b1;
  logic        as_n_i = 1'b1;
  logic        reset_n_i = 1'b1;
  logic        halt_n_i = 1'b1;
  logic        rom_cs_n_o, ram_cs_n_o;

  int total = 0, bad = 0;
  bit model_boot = 1'b1;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  boot_ovl_ctrl u_boot_ovl_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .fc_i(fc_i),
    .rw_i(rw_i), .as_n_i(as_n_i), .reset_n_i(reset_n_i),
    .halt_n_i(halt_n_i), .rom_cs_n_o(rom_cs_n_o), .ram_cs_n_o(ram_cs_n_o)
  );

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s {rom_cs_n,ram_cs_n} got=%b exp=%b", req, got, exp);
    end
  endtask

  function automatic logic [1:0] expect_sel(input logic [23:0] a, input logic rw, input bit boot);
    bit low = a[23:18] == 6'd0;
    bit rom = a[23:20] == 4'hE;
    bit ram = a[23:20] == 4'h0;
    bit ovl = boot && low && rw;
    return {~(rom | ovl), ~(ram & ~ovl)};
  endfunction

  function automatic bit is_trig(input logic [23:0] a, input logic [2:0] fc);
    return fc == 3'b101 && (a[19:18] == 2'b01 || a[19:18] == 2'b10);
  endfunction

  // one bus cycle: strobe low for hold clocks, selects checked mid-strobe
  task automatic bus(input string req, input logic [23:0] a, input logic [2:0] fc,
                     input logic rw, input int hold);
    @(negedge clk_i);
    addr_i = a; fc_i = fc; rw_i = rw; as_n_i = 1'b0;
    #4 chk(req, {rom_cs_n_o, ram_cs_n_o}, expect_sel(a, rw, model_boot));
    repeat (hold) @(negedge clk_i);
    as_n_i = 1'b1;
    @(negedge clk_i);
    if (is_trig(a, fc)) model_boot = 1'b0;
  endtask

  task automatic hard_reset();
    @(negedge clk_i);
    reset_n_i = 1'b0; halt_n_i = 1'b0;
    @(negedge clk_i);
    reset_n_i = 1'b1; halt_n_i = 1'b1;
    model_boot = 1'b1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle", {rom_cs_n_o, ram_cs_n_o}, 2'b11);
    bus("R1 boot read 0", 24'h000000, 3'b110, 1'b1, 1);
    bus("R3 boot write 0", 24'h000100, 3'b101, 1'b0, 1);

    // R5: wrong function codes or window edges keep boot mode
    bus("R5 sup prog", 24'h040000, 3'b110, 1'b1, 1);
    bus("R5 check", 24'h000000, 3'b110, 1'b1, 1);
    bus("R5 user data", 24'h080000, 3'b001, 1'b0, 1);
    bus("R5 check", 24'h000004, 3'b101, 1'b1, 1);
    bus("R5 below win", 24'h03FFFF, 3'b101, 1'b1, 1);
    bus("R5 above win", 24'h0C0000, 3'b101, 1'b0, 1);
    bus("R5 check", 24'h000008, 3'b101, 1'b1, 1);

    // R4/R6: upper bank, write, long strobe; exit seen next cycle
    bus("R4 trigger", 24'h5BFFFF, 3'b101, 1'b0, 6);
    bus("R6 R7 low read", 24'h000000, 3'b110, 1'b1, 1);
    bus("R7 low write", 24'h03FFFC, 3'b101, 1'b0, 1);
    bus("R9 rom normal", 24'hE00010, 3'b110, 1'b1, 1);

    // R8: CPU reset instruction pulse alone
    @(negedge clk_i); reset_n_i = 1'b0;
    repeat (4) @(negedge clk_i); reset_n_i = 1'b1;
    bus("R8 soft reset", 24'h000000, 3'b110, 1'b1, 1);
    hard_reset();
    bus("R8 hard reset", 24'h000000, 3'b110, 1'b1, 1);

    // R10: hard reset coincides with the exiting strobe rise
    @(negedge clk_i);
    addr_i = 24'h040000; fc_i = 3'b101; rw_i = 1'b1; as_n_i = 1'b0;
    repeat (2) @(negedge clk_i);
    as_n_i = 1'b1; reset_n_i = 1'b0; halt_n_i = 1'b0;
    @(negedge clk_i);
    reset_n_i = 1'b1; halt_n_i = 1'b1;
    model_boot = 1'b1;
    bus("R10 set wins", 24'h000000, 3'b110, 1'b1, 1);

    // sweep in boot mode: re-enter before each access
    for (int hi = 0; hi < 64; hi++)
      for (int fc = 0; fc < 8; fc++)
        for (int rw = 0; rw < 2; rw++) begin
          if (!model_boot) hard_reset();
          bus("R2 R4 R9 boot sweep", {hi[5:0], 18'h1F0}, fc[2:0], rw[0], 1);
        end
    bus("R4 exit", 24'h840000, 3'b101, 1'b1, 1);
    // sweep in normal mode
    for (int hi = 0; hi < 64; hi++)
      for (int fc = 0; fc < 8; fc++)
        for (int rw = 0; rw < 2; rw++)
          bus("R7 R9 normal sweep", {hi[5:0], 18'h2A8}, fc[2:0], rw[0], 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule